// File: doc/BRIEF.md
# Configuration Register File with Group Commit

This block holds the 27 byte-wide configuration registers of a measurement device that has two converters. A command layer in front of it, which is not part of this block, opens a block write by giving a first address and a byte count. It then streams data bytes and closes the command with either a completion strobe or an abort strobe. The address advances by one after each byte.

Most registers take a new byte as soon as it arrives. Two sets of registers behave differently: the first converter's set (03h–06h, 0Dh–0Fh) and the second converter's set (15h, 16h). Bytes written to these sets go into a shadow copy first. The shadow copy is applied in a single cycle when the command completes, and it is dropped if the command is aborted.

On a commit, each converter whose set was written receives a one-cycle restart pulse. A restart of the first converter also forces the data-ready output high. Register contents are available as a flat vector and through a combinational read port.

Top module: `cfg_regbank`

## Requirements
- R1: After reset, each register holds its default value: 01h=11h, 02h=05h, 04h=80h, 05h=04h, 06h=01h, 0Ch=40h, 0Dh=BBh, 16h=01h, 1Ah=40h. All other writable registers reset to 00h. Register 00h holds {DEV_ID[2:0], REV_ID[4:0]}. Register i appears at cfg_flat[8*i+7:8*i].
- R2: Register 00h cannot be written. The following bits always read 0: 01h bits 7:5 and 3:2, 02h bits 7:4, 0Fh bits 7:6, 10h and 11h bits 6:5.
- R3: A block write puts each byte at the current address and then increments the address. A register outside the two sets shows its new value on the clock edge that accepts its byte.
- R4: The block ignores bytes at addresses above 1Ah. It also ignores bytes that arrive after cmd_count bytes have been consumed.
- R5: Registers in either set (set 1: 03h–06h, 0Dh–0Fh; set 2: 15h, 16h) do not change until a command completes. The read port and cfg_flat show committed values only.
- R6: On cmd_done, every set register written during the command takes its buffered value on the same edge.
- R7: cmd_abort discards the buffered set bytes, so those registers keep their old values. A cmd_start that arrives while a command is open also discards them. If cmd_abort and cmd_done arrive together, the abort takes effect.
- R8: restart1 goes high for one cycle, on the commit edge, if any set-1 register was written. This happens once per command, however many set-1 registers were written. restart2 behaves the same way for set 2. With nothing buffered, neither pulse occurs.
- R9: drdy is high after reset. drdy goes high whenever restart1 fires. A conv1_result pulse drives drdy low.
- R10: The block ignores data bytes and cmd_done when no command is open. rd_data returns 00h for addresses above 1Ah.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Opens a block write |
| cmd_addr | input | 5 | First register address of the block |
| cmd_count | input | 5 | Number of bytes the command may write |
| byte_valid | input | 1 | A data byte is present |
| byte_data | input | 8 | Data byte |
| cmd_done | input | 1 | Command finished normally |
| cmd_abort | input | 1 | Command cut short |
| conv1_result | input | 1 | Converter 1 produced a result; clears drdy |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Committed value at rd_addr |
| cfg_flat | output | 216 | All committed registers, register i at bits 8i+7:8i |
| restart1 | output | 1 | One-cycle restart request to converter 1 |
| restart2 | output | 1 | One-cycle restart request to converter 2 |
| drdy | output | 1 | Data-ready indication for converter 1 |

## Verification
The bench watches the set registers while bytes for them are still arriving. A design that applies them at once would show them before the commit edge. The bench aborts commands and restarts open ones, and a design that keeps stale shadow bytes would then apply old data at a later commit. Writes that cover several set-1 registers check that restart1 fires exactly once and never without a set-1 write. Blocks that run past 1Ah, past their byte count, or start at 00h expose a design that wraps the address or writes read-only and reserved bits.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

  localparam int unsigned NREG = 27;
  localparam int unsigned DW   = 8;
  localparam int unsigned AW   = $clog2(NREG);
  localparam int unsigned CW   = $clog2(NREG + 1);

  typedef enum logic [1:0] {
    GRP_NONE  = 2'd0,
    GRP_CONV1 = 2'd1,
    GRP_CONV2 = 2'd2
  } grp_e;

  // reset contents of the writable registers
  function automatic logic [DW-1:0] reg_default(int unsigned idx);
    case (idx)
      'h01:    return 8'h11;
      'h02:    return 8'h05;
      'h04:    return 8'h80;
      'h05:    return 8'h04;
      'h06:    return 8'h01;
      'h0C:    return 8'h40;
      'h0D:    return 8'hBB;
      'h16:    return 8'h01;
      'h1A:    return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  // commit set each register belongs to
  function automatic grp_e reg_group(int unsigned idx);
    if ((idx >= 'h03 && idx <= 'h06) || (idx >= 'h0D && idx <= 'h0F))
      return GRP_CONV1;
    if (idx == 'h15 || idx == 'h16)
      return GRP_CONV2;
    return GRP_NONE;
  endfunction

  // bits that can hold a one
  function automatic logic [DW-1:0] wr_mask(int unsigned idx);
    case (idx)
      'h00:    return 8'h00;
      'h01:    return 8'h13;
      'h02:    return 8'h0F;
      'h0F:    return 8'h3F;
      'h10:    return 8'h9F;
      'h11:    return 8'h9F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [NREG-1:0] group_mask(grp_e g);
    logic [NREG-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < NREG; i++) m[i] = (reg_group(i) == g);
    return m;
  endfunction

endpackage

// File: rtl/cfg_cmd_seq.sv
module cfg_cmd_seq
  import cfg_regbank_pkg::*;
#(
  parameter int unsigned NR = NREG,
  parameter int unsigned AWD = $clog2(NR),
  parameter int unsigned CWD = $clog2(NR + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_start,
  input  logic [AWD-1:0] cmd_addr,
  input  logic [CWD-1:0] cmd_count,
  input  logic           byte_valid,
  input  logic           cmd_done,
  input  logic           cmd_abort,
  output logic           wr_en,
  output logic [AWD-1:0] wr_idx,
  output logic           commit_go,
  output logic           discard
);

  localparam int unsigned PW = AWD + 1;

  logic           active_q, active_d;
  logic [PW-1:0]  ptr_q, ptr_d;
  logic [CWD-1:0] left_q, left_d;
  logic           end_cmd, accept, in_range, open_new;

  always_comb begin
    end_cmd   = cmd_done | cmd_abort;
    open_new  = cmd_start & ~end_cmd;
    accept    = active_q & byte_valid & ~end_cmd & ~cmd_start & (left_q != '0);
    in_range  = (ptr_q < PW'(NR));
    wr_en     = accept & in_range;
    wr_idx    = ptr_q[AWD-1:0];
    commit_go = active_q & cmd_done & ~cmd_abort;
    discard   = cmd_abort | open_new;

    active_d = active_q;
    ptr_d    = ptr_q;
    left_d   = left_q;
    if (end_cmd) begin
      active_d = 1'b0;
    end else if (cmd_start) begin
      active_d = 1'b1;
      ptr_d    = {1'b0, cmd_addr};
      left_d   = cmd_count;
    end else if (accept) begin
      left_d = left_q - 1'b1;
      if (in_range) ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ptr_q    <= '0;
      left_q   <= '0;
    end else begin
      active_q <= active_d;
      ptr_q    <= ptr_d;
      left_q   <= left_d;
    end
  end

endmodule

// File: rtl/cfg_shadow_store.sv
module cfg_shadow_store
  import cfg_regbank_pkg::*;
#(
  parameter int unsigned NR  = NREG,
  parameter int unsigned DWD = DW,
  parameter int unsigned AWD = $clog2(NR)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AWD-1:0]          wr_idx,
  input  logic [DWD-1:0]          wr_data,
  input  logic                    clear,
  output logic [NR-1:0]           pend,
  output logic [NR-1:0][DWD-1:0]  shad
);

  for (genvar i = 0; i < NR; i++) begin : g_slot
    if (reg_group(i) != GRP_NONE) begin : g_buf
      logic           hit;
      logic           pend_q, pend_d;
      logic [DWD-1:0] data_q, data_d;

      always_comb begin
        hit    = wr_en & (wr_idx == AWD'(i));
        pend_d = pend_q;
        data_d = data_q;
        if (clear) pend_d = 1'b0;
        else if (hit) begin
          pend_d = 1'b1;
          data_d = wr_data;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q <= 1'b0;
          data_q <= '0;
        end else begin
          pend_q <= pend_d;
          data_q <= data_d;
        end
      end

      assign pend[i] = pend_q;
      assign shad[i] = data_q;
    end else begin : g_none
      assign pend[i] = 1'b0;
      assign shad[i] = '0;
    end
  end

endmodule

// File: rtl/cfg_live_regs.sv
module cfg_live_regs
  import cfg_regbank_pkg::*;
#(
  parameter int unsigned NR     = NREG,
  parameter int unsigned DWD    = DW,
  parameter int unsigned AWD    = $clog2(NR),
  parameter logic [DWD-1:0] ID_VAL = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AWD-1:0]          wr_idx,
  input  logic [DWD-1:0]          wr_data,
  input  logic [NR-1:0]           commit_en,
  input  logic [NR-1:0][DWD-1:0]  shad,
  output logic [NR-1:0][DWD-1:0]  live
);

  for (genvar i = 0; i < NR; i++) begin : g_reg
    if (i == 0) begin : g_id
      assign live[i] = ID_VAL;
    end else begin : g_rw
      localparam logic [DWD-1:0] MASK = wr_mask(i);
      localparam logic [DWD-1:0] RST  = reg_default(i);
      logic           en;
      logic [DWD-1:0] src;
      logic [DWD-1:0] val_q, val_d;

      if (reg_group(i) != GRP_NONE) begin : g_grp
        assign en  = commit_en[i];
        assign src = shad[i];
      end else begin : g_imm
        assign en  = wr_en & (wr_idx == AWD'(i));
        assign src = wr_data;
      end

      always_comb begin
        val_d = val_q;
        if (en) val_d = src & MASK;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= RST;
        else        val_q <= val_d;
      end

      assign live[i] = val_q;
    end
  end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_regbank_pkg::*;
#(
  parameter logic [2:0] DEV_ID = 3'd1,
  parameter logic [4:0] REV_ID = 5'd0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_start,
  input  logic [AW-1:0]        cmd_addr,
  input  logic [CW-1:0]        cmd_count,
  input  logic                 byte_valid,
  input  logic [DW-1:0]        byte_data,
  input  logic                 cmd_done,
  input  logic                 cmd_abort,
  input  logic                 conv1_result,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data,
  output logic [NREG*DW-1:0]   cfg_flat,
  output logic                 restart1,
  output logic                 restart2,
  output logic                 drdy
);

  localparam logic [NREG-1:0] G1_MASK = group_mask(GRP_CONV1);
  localparam logic [NREG-1:0] G2_MASK = group_mask(GRP_CONV2);
  localparam logic [DW-1:0]   ID_VAL  = {DEV_ID, REV_ID};

  logic                       wr_en, commit_go, discard, clear;
  logic [AW-1:0]              wr_idx;
  logic [NREG-1:0]            pend, commit_en;
  logic [NREG-1:0][DW-1:0]    shad, live;
  logic                       r1_q, r1_d, r2_q, r2_d, drdy_q, drdy_d;

  cfg_cmd_seq #(.NR(NREG), .AWD(AW), .CWD(CW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_start(cmd_start), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
    .byte_valid(byte_valid), .cmd_done(cmd_done), .cmd_abort(cmd_abort),
    .wr_en(wr_en), .wr_idx(wr_idx), .commit_go(commit_go), .discard(discard)
  );

  assign clear     = discard | commit_go;
  assign commit_en = pend & {NREG{commit_go}};

  cfg_shadow_store #(.NR(NREG), .DWD(DW), .AWD(AW)) u_shadow (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(byte_data),
    .clear(clear), .pend(pend), .shad(shad)
  );

  cfg_live_regs #(.NR(NREG), .DWD(DW), .AWD(AW), .ID_VAL(ID_VAL)) u_live (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(byte_data),
    .commit_en(commit_en), .shad(shad), .live(live)
  );

  always_comb begin
    r1_d   = commit_go & |(pend & G1_MASK);
    r2_d   = commit_go & |(pend & G2_MASK);
    drdy_d = drdy_q;
    if (r1_d)              drdy_d = 1'b1;
    else if (conv1_result) drdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q   <= 1'b0;
      r2_q   <= 1'b0;
      drdy_q <= 1'b1;
    end else begin
      r1_q   <= r1_d;
      r2_q   <= r2_d;
      drdy_q <= drdy_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int unsigned i = 0; i < NREG; i++)
      if (rd_addr == AW'(i)) rd_data = live[i];
  end

  assign cfg_flat = live;
  assign restart1 = r1_q;
  assign restart2 = r2_q;
  assign drdy     = drdy_q;

endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk
  import cfg_regbank_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_done,
  input logic               cmd_abort,
  input logic               restart1,
  input logic               restart2,
  input logic               drdy,
  input logic [NREG*DW-1:0] cfg_flat
);

  p_restart1_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart1 |=> !restart1);

  p_restart2_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart2 |-> $past(cmd_done));

  p_drdy_on_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart1 |-> drdy);

  p_abort_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_abort) |-> (!restart1 && !restart2));

  p_set1_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_done) |-> $stable(cfg_flat['h03*DW +: DW]));

  p_set2_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_done) |-> $stable(cfg_flat['h15*DW +: DW]));

endmodule

bind cfg_regbank cfg_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .cmd_abort(cmd_abort),
  .restart1(restart1), .restart2(restart2), .drdy(drdy), .cfg_flat(cfg_flat)
);

// File: tb/tb_cfg_regbank.sv
module tb_cfg_regbank;

  localparam int NR = 27;

  logic         clk, rst_n;
  logic         cmd_start, byte_valid, cmd_done, cmd_abort, conv1_result;
  logic [4:0]   cmd_addr, cmd_count, rd_addr;
  logic [7:0]   byte_data, rd_data;
  logic [NR*8-1:0] cfg_flat;
  logic         restart1, restart2, drdy;

  cfg_regbank #(.DEV_ID(3'd5), .REV_ID(5'd3)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_count(cmd_count), .byte_valid(byte_valid), .byte_data(byte_data),
    .cmd_done(cmd_done), .cmd_abort(cmd_abort), .conv1_result(conv1_result),
    .rd_addr(rd_addr), .rd_data(rd_data), .cfg_flat(cfg_flat),
    .restart1(restart1), .restart2(restart2), .drdy(drdy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_reg [NR];
  logic [7:0] sh_val  [NR];
  bit         sh_pend [NR];
  bit         exp_drdy;
  logic [7:0] bq [32];

  function automatic logic [7:0] m_def(int i);
    case (i)
      0: return 8'hA3;   1: return 8'h11;  2: return 8'h05;
      4: return 8'h80;   5: return 8'h04;  6: return 8'h01;
      12: return 8'h40;  13: return 8'hBB; 22: return 8'h01;
      26: return 8'h40;  default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_mask(int i);
    case (i)
      1: return 8'h13;  2: return 8'h0F;  15: return 8'h3F;
      16: return 8'h9F; 17: return 8'h9F; default: return 8'hFF;
    endcase
  endfunction

  function automatic int m_set(int i);
    if ((i >= 3 && i <= 6) || (i >= 13 && i <= 15)) return 1;
    if (i == 21 || i == 22) return 2;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    int bad = -1;
    int ra;
    for (int i = 0; i < NR; i++)
      if (bad < 0 && cfg_flat[i*8 +: 8] !== exp_reg[i]) bad = i;
    if (bad < 0) chk(1'b1, req, "regs", 0, 0);
    else chk(1'b0, req, $sformatf("reg %0h", bad), {24'h0, cfg_flat[bad*8 +: 8]}, {24'h0, exp_reg[bad]});
    ra = $urandom_range(0, 31);
    rd_addr = 5'(ra);
    #1;
    chk(rd_data === (ra < NR ? exp_reg[ra] : 8'h00), req, $sformatf("read %0h", ra),
        {24'h0, rd_data}, {24'h0, (ra < NR ? exp_reg[ra] : 8'h00)});
  endtask

  // kind: 0 complete, 1 abort, 2 leave open
  task automatic send_cmd(input int addr, input int cnt, input int nb, input int kind,
                          input string req);
    int p = addr, left = cnt;
    bit e1 = 0, e2 = 0;
    cmd_start = 1; cmd_addr = 5'(addr); cmd_count = 5'(cnt);
    @(negedge clk);
    cmd_start = 0;
    for (int i = 0; i < NR; i++) sh_pend[i] = 0;
    for (int k = 0; k < nb; k++) begin
      byte_valid = 1; byte_data = bq[k];
      @(negedge clk);
      if (left > 0) begin
        if (p < NR && p != 0) begin
          if (m_set(p) != 0) begin sh_val[p] = bq[k]; sh_pend[p] = 1; end
          else exp_reg[p] = bq[k] & m_mask(p);
        end
        if (p < NR) p++;
        left--;
      end
      compare_all(req);
    end
    byte_valid = 0;
    if (kind == 0) begin
      cmd_done = 1;
      @(negedge clk);
      cmd_done = 0;
      for (int i = 0; i < NR; i++)
        if (sh_pend[i]) begin
          exp_reg[i] = sh_val[i] & m_mask(i);
          if (m_set(i) == 1) e1 = 1; else e2 = 1;
          sh_pend[i] = 0;
        end
      if (e1) exp_drdy = 1;
      chk(restart1 === e1, "R8", "restart1 at commit", restart1, e1);
      chk(restart2 === e2, "R8", "restart2 at commit", restart2, e2);
      chk(drdy === exp_drdy, "R9", "drdy at commit", drdy, exp_drdy);
      compare_all("R6");
      @(negedge clk);
      chk(restart1 === 1'b0 && restart2 === 1'b0, "R8", "restart length",
          {restart1, restart2}, 0);
    end else if (kind == 1) begin
      cmd_abort = 1;
      @(negedge clk);
      cmd_abort = 0;
      for (int i = 0; i < NR; i++) sh_pend[i] = 0;
      chk(restart1 === 1'b0 && restart2 === 1'b0, "R7", "no restart on abort",
          {restart1, restart2}, 0);
      compare_all("R7");
    end
  endtask

  task automatic result_pulse();
    conv1_result = 1;
    @(negedge clk);
    conv1_result = 0;
    exp_drdy = 0;
    chk(drdy === 1'b0, "R9", "drdy after result", drdy, 0);
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "WATCHDOG", "timeout", 0, 1);
    report();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; cmd_start = 0; byte_valid = 0; cmd_done = 0; cmd_abort = 0;
    conv1_result = 0; cmd_addr = 0; cmd_count = 0; byte_data = 0; rd_addr = 0;
    for (int i = 0; i < NR; i++) begin exp_reg[i] = m_def(i); sh_pend[i] = 0; sh_val[i] = 0; end
    exp_drdy = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    compare_all("R1");
    chk(drdy === 1'b1, "R9", "drdy reset", drdy, 1);
    chk(restart1 === 1'b0 && restart2 === 1'b0, "R1", "restarts reset", {restart1, restart2}, 0);
    rd_addr = 0; #1;
    chk(rd_data === 8'hA3, "R1", "ID read", rd_data, 8'hA3);
    rd_addr = 30; #1;
    chk(rd_data === 8'h00, "R10", "read past end", rd_data, 0);

    // R2 R3: write from 00h through 02h with all ones
    bq[0] = 8'hFF; bq[1] = 8'hFF; bq[2] = 8'hFF;
    send_cmd(0, 3, 3, 0, "R2");
    chk(cfg_flat[15:8] === 8'h13, "R2", "reserved bits 01h", cfg_flat[15:8], 8'h13);

    // R3 R5 R6 R8: set-1 block, single restart
    for (int k = 0; k < 6; k++) bq[k] = 8'h30 + 8'(k);
    send_cmd(2, 6, 6, 0, "R5");

    // R7: set-2 write aborted
    bq[0] = 8'hAA; bq[1] = 8'h55;
    send_cmd(21, 2, 2, 1, "R7");

    // R4: beyond 1Ah ignored, set 2 only
    for (int k = 0; k < 10; k++) bq[k] = 8'hC0 + 8'(k);
    send_cmd(20, 10, 10, 0, "R4");
    chk(cfg_flat[26*8 +: 8] === 8'hC6, "R4", "last reg 1Ah", cfg_flat[26*8 +: 8], 8'hC6);

    // R4: byte count limit
    for (int k = 0; k < 5; k++) bq[k] = 8'h71 + 8'(k);
    send_cmd(7, 2, 5, 0, "R4");
    chk(cfg_flat[9*8 +: 8] === 8'h00, "R4", "past count", cfg_flat[9*8 +: 8], 8'h00);

    // R10: bytes and done without an open command
    byte_valid = 1; byte_data = 8'h99;
    @(negedge clk);
    cmd_done = 1;
    @(negedge clk);
    byte_valid = 0; cmd_done = 0;
    chk(restart1 === 1'b0, "R10", "done without command", restart1, 0);
    compare_all("R10");

    // R9: result clears drdy, restart sets it
    result_pulse();
    bq[0] = 8'h0E;
    send_cmd(13, 1, 1, 0, "R9");

    // R7: reopening discards the buffered bytes
    bq[0] = 8'h12; bq[1] = 8'h34;
    send_cmd(5, 2, 2, 2, "R7");
    bq[0] = 8'h21;
    send_cmd(1, 1, 1, 0, "R7");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int nb, kind;
      nb = $urandom_range(0, 12);
      for (int k = 0; k < nb; k++) bq[k] = 8'($urandom());
      kind = $urandom_range(0, 9);
      kind = (kind < 6) ? 0 : (kind < 8) ? 1 : 2;
      send_cmd($urandom_range(0, 31), $urandom_range(0, 27), nb, kind, "R6");
      if ($urandom_range(0, 4) == 0) result_pulse();
    end
    if (1) begin
      cmd_abort = 1; @(negedge clk); cmd_abort = 0;
      compare_all("R7");
    end
    report();
  end

endmodule